// File: doc/BRIEF.md
# NAND Sector ECC Syndrome Corrector

This block takes the three-byte Hamming check code stored beside a 512-byte NAND sector and the three-byte code recomputed over the same sector as it was read back. On a start strobe it forms their bytewise difference and, one clock later, reports what kind of damage the sector has: none, a never-programmed page, a single flipped data bit that can be repaired, a flipped bit inside the stored code, or damage it cannot repair.

When a single data bit is at fault, the block gives the byte number (0 to 511) and the bit number (0 to 7) inside that byte. A small repair port can be used while the sector is copied out of a buffer: the caller shows it each byte together with that byte's address, and the port flips the faulty bit in the one matching byte and passes all other bytes through unchanged.

Top module: `ecc_fix_corrector`

## Requirements
- R1: After reset, done_o is 0, status_o is 0 and both location outputs are 0.
- R2: done_o is high for exactly the one cycle after each cycle in which start_i is high. The status and location outputs change only in that cycle and then hold until the next start.
- R3: With the difference (stored XOR computed) equal to zero, status_o is 0 (clean).
- R4: With all three stored bytes equal to 8'hFF, status_o is 0 (clean), whatever the computed code is, and this takes priority over every test below.
- R5: With every one of the twelve adjacent bit pairs (bits 1/0, 3/2, 5/4, 7/6 of each difference byte) holding unequal values, status_o is 1 (correctable data bit).
- R6: For status 1, bit_idx_o bits 0, 1 and 2 equal difference byte 2 bits 3, 5 and 7.
- R7: For status 1, byte_idx_o bits 3..0 equal difference byte 0 bits 7, 5, 3, 1, bits 7..4 equal difference byte 1 bits 7, 5, 3, 1, and bit 8 equals difference byte 2 bit 1.
- R8: With exactly one bit set in the 24-bit difference, status_o is 2 (error in the stored code).
- R9: Any other difference gives status_o 3 (uncorrectable).
- R10: flip_data_o equals flip_data_i XOR (1 << bit_idx_o) when status_o is 1 and flip_addr_i equals byte_idx_o; otherwise it equals flip_data_i.
- R11: byte_idx_o and bit_idx_o are 0 whenever status_o is not 1.

Byte 0 of each 24-bit code is in bits 7:0, byte 1 in bits 15:8, byte 2 in bits 23:16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Evaluate the codes presented in this cycle |
| stored_ecc_i | input | 24 | Code read from the spare area |
| calc_ecc_i | input | 24 | Code recomputed over the read data |
| done_o | output | 1 | One-cycle pulse when a result is ready |
| status_o | output | 2 | 0 clean, 1 corrected, 2 code error, 3 uncorrectable |
| byte_idx_o | output | 9 | Faulty byte number |
| bit_idx_o | output | 3 | Faulty bit number in that byte |
| flip_addr_i | input | 9 | Address of the byte shown to the repair port |
| flip_data_i | input | 8 | Byte shown to the repair port |
| flip_data_o | output | 8 | Repaired or passed-through byte |

## Verification
Equal codes and all-0xFF stored codes set against random computed codes tell the clean path apart from the bypass. Differences built from a chosen byte and bit number test the location scramble one index bit at a time, and one-hot differences separate the code-error case from the correctable case. Fully random code pairs, nearly all uncorrectable, show that nothing else leaks into the lower classes. The repair port is shown the matching address and random other addresses after every result, so its flip and its pass-through are both observed.

// File: rtl/ecc_fix_pkg.sv
package ecc_fix_pkg;
    localparam int BYTE_W     = 8;
    localparam int CODE_BYTES = 3;
    localparam int CODE_W     = BYTE_W * CODE_BYTES;
    localparam int PAIRS      = CODE_W / 2;
    localparam int SECTOR     = 512;
    localparam int BYTE_IDX_W = $clog2(SECTOR);
    localparam int BIT_IDX_W  = $clog2(BYTE_W);

    typedef enum logic [1:0] {
        ST_CLEAN   = 2'd0,
        ST_FIXED   = 2'd1,
        ST_CODEERR = 2'd2,
        ST_FATAL   = 2'd3
    } fix_status_e;

    typedef struct packed {
        logic                  done;
        fix_status_e           status;
        logic [BYTE_IDX_W-1:0] byte_idx;
        logic [BIT_IDX_W-1:0]  bit_idx;
    } fix_state_t;
endpackage

// File: rtl/ecc_fix_classify.sv
module ecc_fix_classify
    import ecc_fix_pkg::*;
(
    input  logic [CODE_W-1:0] stored_i,
    input  logic [CODE_W-1:0] calc_i,
    output logic [CODE_W-1:0] diff_o,
    output fix_status_e       status_o
);
    logic [PAIRS-1:0] pair_split;
    logic             unwritten;

    assign diff_o    = stored_i ^ calc_i;
    assign unwritten = &stored_i;

    for (genvar p = 0; p < PAIRS; p++) begin : g_pair
        assign pair_split[p] = diff_o[2*p+1] ^ diff_o[2*p];
    end

    always_comb begin
        if (diff_o == '0)            status_o = ST_CLEAN;
        else if (unwritten)          status_o = ST_CLEAN;
        else if (&pair_split)        status_o = ST_FIXED;
        else if ($onehot(diff_o))    status_o = ST_CODEERR;
        else                         status_o = ST_FATAL;
    end
endmodule

// File: rtl/ecc_fix_locate.sv
module ecc_fix_locate
    import ecc_fix_pkg::*;
(
    input  logic [PAIRS-1:0]      upper_i,
    output logic [BYTE_IDX_W-1:0] byte_idx_o,
    output logic [BIT_IDX_W-1:0]  bit_idx_o
);
    // Upper bit of pair j sits at difference bit 2j+1; pairs 0..8 carry
    // the byte number LSB first, pairs 9..11 the bit number.
    assign byte_idx_o = upper_i[BYTE_IDX_W-1:0];
    assign bit_idx_o  = upper_i[BYTE_IDX_W +: BIT_IDX_W];
endmodule

// File: rtl/ecc_fix_flip.sv
module ecc_fix_flip
    import ecc_fix_pkg::*;
(
    input  logic                  armed_i,
    input  logic [BYTE_IDX_W-1:0] byte_idx_i,
    input  logic [BIT_IDX_W-1:0]  bit_idx_i,
    input  logic [BYTE_IDX_W-1:0] addr_i,
    input  logic [BYTE_W-1:0]     data_i,
    output logic [BYTE_W-1:0]     data_o
);
    logic [BYTE_W-1:0] mask;
    always_comb begin
        mask = '0;
        if (armed_i && addr_i == byte_idx_i) mask[bit_idx_i] = 1'b1;
        data_o = data_i ^ mask;
    end
endmodule

// File: rtl/ecc_fix_corrector.sv
module ecc_fix_corrector
    import ecc_fix_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic [CODE_W-1:0]     stored_ecc_i,
    input  logic [CODE_W-1:0]     calc_ecc_i,
    output logic                  done_o,
    output logic [1:0]            status_o,
    output logic [BYTE_IDX_W-1:0] byte_idx_o,
    output logic [BIT_IDX_W-1:0]  bit_idx_o,
    input  logic [BYTE_IDX_W-1:0] flip_addr_i,
    input  logic [BYTE_W-1:0]     flip_data_i,
    output logic [BYTE_W-1:0]     flip_data_o
);
    logic [CODE_W-1:0]     diff;
    fix_status_e           cls;
    logic [PAIRS-1:0]      upper;
    logic [BYTE_IDX_W-1:0] loc_byte;
    logic [BIT_IDX_W-1:0]  loc_bit;
    fix_state_t            st_d, st_q;

    ecc_fix_classify u_classify (
        .stored_i (stored_ecc_i),
        .calc_i   (calc_ecc_i),
        .diff_o   (diff),
        .status_o (cls)
    );

    for (genvar j = 0; j < PAIRS; j++) begin : g_upper
        assign upper[j] = diff[2*j+1];
    end

    ecc_fix_locate u_locate (
        .upper_i    (upper),
        .byte_idx_o (loc_byte),
        .bit_idx_o  (loc_bit)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (start_i) begin
            st_d.done     = 1'b1;
            st_d.status   = cls;
            st_d.byte_idx = (cls == ST_FIXED) ? loc_byte : '0;
            st_d.bit_idx  = (cls == ST_FIXED) ? loc_bit  : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{done: 1'b0, status: ST_CLEAN, byte_idx: '0, bit_idx: '0};
        else        st_q <= st_d;
    end

    assign done_o     = st_q.done;
    assign status_o   = st_q.status;
    assign byte_idx_o = st_q.byte_idx;
    assign bit_idx_o  = st_q.bit_idx;

    ecc_fix_flip u_flip (
        .armed_i    (st_q.status == ST_FIXED),
        .byte_idx_i (st_q.byte_idx),
        .bit_idx_i  (st_q.bit_idx),
        .addr_i     (flip_addr_i),
        .data_i     (flip_data_i),
        .data_o     (flip_data_o)
    );

    p_done_after_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> done_o);
    p_done_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> !done_o);
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> $stable(status_o) && $stable(byte_idx_o) && $stable(bit_idx_o));
    p_clean_equal_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && stored_ecc_i == calc_ecc_i) |=> status_o == 2'd0);
    p_unwritten_bypass_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && &stored_ecc_i) |=> status_o == 2'd0);
    p_onehot_codeerr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && $countones(stored_ecc_i ^ calc_ecc_i) == 1 && !(&stored_ecc_i))
        |=> status_o == 2'd2);
    p_loc_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        status_o != 2'd1 |-> byte_idx_o == '0 && bit_idx_o == '0);
    p_flip_pass_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o != 2'd1 || flip_addr_i != byte_idx_o) |-> flip_data_o == flip_data_i);
    p_flip_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o == 2'd1 && flip_addr_i == byte_idx_o)
        |-> $countones(flip_data_o ^ flip_data_i) == 1);
endmodule

// File: tb/ecc_fix_corrector_bench.sv
module ecc_fix_corrector_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [23:0] stored_ecc_i = '0;
    logic [23:0] calc_ecc_i = '0;
    logic        done_o;
    logic [1:0]  status_o;
    logic [8:0]  byte_idx_o;
    logic [2:0]  bit_idx_o;
    logic [8:0]  flip_addr_i = '0;
    logic [7:0]  flip_data_i = '0;
    logic [7:0]  flip_data_o;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    ecc_fix_corrector u_ecc_fix_corrector (.*);

    function automatic logic [1:0] exp_status(logic [23:0] s, logic [23:0] c);
        logic [23:0] d = s ^ c;
        bit split = 1'b1;
        for (int p = 0; p < 12; p++) if (d[2*p+1] == d[2*p]) split = 1'b0;
        if (d == 0)                  return 2'd0;
        if (s == 24'hFFFFFF)         return 2'd0;
        if (split)                   return 2'd1;
        if ($countones(d) == 1)      return 2'd2;
        return 2'd3;
    endfunction

    function automatic logic [8:0] exp_byte(logic [23:0] d);
        return {d[17], d[15], d[13], d[11], d[9], d[7], d[5], d[3], d[1]};
    endfunction

    function automatic logic [2:0] exp_bit(logic [23:0] d);
        return {d[23], d[21], d[19]};
    endfunction

    // difference that points at byte b, bit k
    function automatic logic [23:0] make_diff(logic [8:0] b, logic [2:0] k);
        logic [11:0] up = {k, b};
        logic [23:0] d;
        for (int j = 0; j < 12; j++) begin
            d[2*j+1] = up[j];
            d[2*j]   = ~up[j];
        end
        return d;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run(logic [23:0] s, logic [23:0] c);
        logic [1:0] es = exp_status(s, c);
        logic [23:0] d = s ^ c;
        @(negedge clk);
        stored_ecc_i = s; calc_ecc_i = c; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        stored_ecc_i = $urandom; calc_ecc_i = $urandom;
        check("R2 done", done_o, 1);
        case (es)
            2'd0: check("R3/R4 clean", status_o, es);
            2'd1: check("R5 fixed", status_o, es);
            2'd2: check("R8 codeerr", status_o, es);
            default: check("R9 fatal", status_o, es);
        endcase
        if (es == 2'd1) begin
            check("R7 byte", byte_idx_o, exp_byte(d));
            check("R6 bit", bit_idx_o, exp_bit(d));
            flip_addr_i = exp_byte(d); flip_data_i = $urandom;
            #1 check("R10 flip", flip_data_o, flip_data_i ^ (8'd1 << exp_bit(d)));
        end else begin
            check("R11 loc", {byte_idx_o, bit_idx_o}, 0);
            flip_addr_i = 9'(exp_byte(d)); flip_data_i = $urandom;
            #1 check("R10 pass", flip_data_o, flip_data_i);
        end
        flip_addr_i = $urandom; flip_data_i = $urandom;
        #1 if (es != 2'd1 || flip_addr_i != byte_idx_o)
            check("R10 other", flip_data_o, flip_data_i);
        @(negedge clk);
        check("R2 pulse", done_o, 0);
        check("R2 hold", status_o, es);
    endtask

    initial begin
        void'($urandom(32'h5EC7_0A11));
        repeat (3) @(negedge clk);
        check("R1 done", done_o, 0);
        check("R1 status", status_o, 0);
        check("R1 loc", {byte_idx_o, bit_idx_o}, 0);
        rst_n = 1'b1;
        // directed
        run(24'h123456, 24'h123456);
        run(24'hFFFFFF, 24'h000000);
        run(24'hFFFFFF, 24'hFFFFFF ^ make_diff(9'h1A5, 3'd6));
        run(24'h000000, make_diff(9'h000, 3'd0));
        run(24'h000000, make_diff(9'h1FF, 3'd7));
        for (int i = 0; i < 12; i++) run(24'h0F0F0F, 24'h0F0F0F ^ make_diff(9'(1 << i), 3'(1 << (i - 9))));
        for (int i = 0; i < 24; i++) run(24'hA5A5A5, 24'hA5A5A5 ^ (24'd1 << i));
        run(24'h000000, 24'h000003);
        run(24'hFFFFFE, 24'h7FFFFE);
        // random
        for (int n = 0; n < 300; n++) begin
            logic [23:0] s = $urandom;
            case ($urandom % 5)
                0: run(s, s);
                1: run(24'hFFFFFF, $urandom);
                2: run(s, s ^ make_diff($urandom, $urandom));
                3: run(s, s ^ (24'd1 << ($urandom % 24)));
                default: run(s, $urandom);
            endcase
        end
        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule